// File: doc/BRIEF.md
# Halt and Hold Power-Down Controller

This block sits next to an 8-bit processor core. It decides when the core stops its clock to save power, and it hands the external bus to another master on request. The core stops in one of two ways. It stops when it executes a halt instruction, reported here by a one-cycle strobe. It also stops when a bus request from another master is granted while the core is running normally. The controller records which of these two events caused the stop. That record then decides which later events may restart the core.

Bus hand-over follows a request/acknowledge pair. A request is granted only at the end of the current bus transfer, or at any time while the core is halted, because the bus is then idle. The acknowledge rises at the edge that grants the request. The address, data and control pins float from the next rising edge onward. When the request goes away, the acknowledge drops at the next rising edge. The pins are driven again half a clock later, at the following falling edge.

The wake-up lines are the five interrupt request lines, passed in as one vector. Masking and priority are handled outside this block.

Top module: `pd_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first edge after it is released, `hlda` is 0, `bus_float` is 0, `pd_active` is 0 and `core_clk_en` is 1.
- R2: A high `halt_stb` at a rising edge, while the core is not powered down, sets `pd_active` after that edge.
- R3: While powered down by a halt, any nonzero value on `irq_lines` at a rising edge clears `pd_active` after that edge. An all-zero vector keeps it set.
- R4: While powered down by a halt, raising and then dropping `hold_req` does not clear `pd_active`. `hlda` still follows the request.
- R5: `hlda` rises only at a rising edge where `hold_req` is 1 and either `xfer_done` is 1 or the core is halted. Once high, it stays high as long as `hold_req` stays 1.
- R6: `bus_float` rises at the rising edge after the one where `hlda` rose.
- R7: When `hlda` is granted while the core is not halted, `pd_active` is set from the edge after the grant onward.
- R8: While powered down by a hold, no value on `irq_lines` clears `pd_active`.
- R9: When `hold_req` is 0 at a rising edge, `hlda` falls at that edge and a hold-caused power-down ends at that edge. `bus_float` stays 1 until the next falling edge and is 0 after it.
- R10: A low `rst_n` at a rising edge ends the power-down, whichever event caused it.
- R11: `core_clk_en` is always the inverse of `pd_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_stb | input | 1 | One-cycle strobe when a halt instruction executes |
| hold_req | input | 1 | Bus request from another master |
| xfer_done | input | 1 | The current bus transfer finishes in this cycle |
| irq_lines | input | NUM_IRQ (5) | Interrupt request lines used as wake-up sources |
| hlda | output | 1 | Bus grant acknowledge |
| bus_float | output | 1 | Floats address, data, read, write and memory/IO pins |
| core_clk_en | output | 1 | Clock enable for the core |
| pd_active | output | 1 | Core is in the power-down state |

## Verification
The bench tries all 32 values of the interrupt vector in two situations. During a halt-caused power-down, every nonzero value must wake the core and zero must not. During a hold-caused power-down, no value may wake it. This shows that the entry cause, and not the wake input, selects the release path.

A hold pulse during a halt shows that removing the request cannot release a halt. A request held against several unfinished transfers shows that the grant waits for the transfer to end. Sampling just before and just after the falling edge that follows the release separates the half-clock bus re-take from a full-clock one. Reset is applied inside each kind of power-down.

// File: rtl/pd_pkg.sv
// Shared types for the power-down controller.
// Assumes: the entry cause needs only three encodings.
package pd_pkg;
    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_HALT = 2'd1,
        PD_HOLD = 2'd2
    } pd_cause_t;
endpackage

// File: rtl/pd_wake_detect.sv
// Combines the interrupt request lines into one wake request.
// Assumes: the lines are already synchronous to clk, and masking is done upstream.
module pd_wake_detect #(
    parameter int NUM_IRQ = 5
) (
    input  logic [NUM_IRQ-1:0] irq_lines,
    output logic               wake
);
    logic [NUM_IRQ:0] chain;

    assign chain[0] = 1'b0;

    // OR chain across the request lines
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_or
        assign chain[i+1] = chain[i] | irq_lines[i];
    end

    assign wake = chain[NUM_IRQ];
endmodule

// File: rtl/pd_hold_arb.sv
// Grants the bus to another master and produces the pin-float enable.
// The grant waits for the end of a transfer, or happens at once while halted.
// The float enable turns on one clock after the grant. It turns off half a clock
// after the grant drops, through a falling-edge register.
// Assumes: hold_req and xfer_done are synchronous to the rising edge.
module pd_hold_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic xfer_done,
    input  logic halted,
    output logic hlda,
    output logic bus_float
);
    logic hlda_q;
    logic float_on_q;
    logic hlda_neg_q;
    logic bus_idle;

    assign bus_idle = xfer_done | halted;

    // Grant flip-flop, sampled on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            hlda_q <= 1'b0;
        else if (!hold_req)
            hlda_q <= 1'b0;
        else if (bus_idle)
            hlda_q <= 1'b1;
    end

    // Float turns on one full clock after the grant
    always_ff @(posedge clk) begin
        if (!rst_n)
            float_on_q <= 1'b0;
        else
            float_on_q <= hlda_q;
    end

    // Copy of the grant on the falling edge, for the half-clock re-take
    always_ff @(negedge clk) begin
        if (!rst_n)
            hlda_neg_q <= 1'b0;
        else
            hlda_neg_q <= hlda_q;
    end

    assign hlda      = hlda_q;
    assign bus_float = float_on_q & hlda_neg_q;

    AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda_q) |-> ($past(hold_req) && $past(bus_idle))) else $error("grant without idle bus"); // R5

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda_q && hold_req) |=> hlda_q) else $error("grant dropped under request"); // R5

    AST_FLOAT_LAGS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(float_on_q) |-> $past(hlda_q)) else $error("float before grant"); // R6
endmodule

// File: rtl/pd_cause_fsm.sv
// Records why the core is powered down and applies the release rule for that cause.
// A halt is released only by a wake request. A hold is released only by removing the request.
// Assumes: halt_stb is a one-cycle strobe from the instruction decoder.
module pd_cause_fsm
    import pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_stb,
    input  logic      hold_req,
    input  logic      hlda,
    input  logic      wake,
    output pd_cause_t cause
);
    pd_cause_t cause_q;
    pd_cause_t cause_d;

    // Next-cause selection by current cause
    always_comb begin
        cause_d = cause_q;
        unique case (cause_q)
            PD_NONE: begin
                if (halt_stb)
                    cause_d = PD_HALT;
                else if (hlda && hold_req)
                    cause_d = PD_HOLD;
            end
            PD_HALT: begin
                if (wake)
                    cause_d = PD_NONE;
            end
            PD_HOLD: begin
                if (!hold_req)
                    cause_d = PD_NONE;
            end
            default: cause_d = PD_NONE;
        endcase
    end

    // Cause register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= PD_NONE;
        else
            cause_q <= cause_d;
    end

    assign cause = cause_q;

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == PD_NONE && halt_stb) |=> (cause_q == PD_HALT)) else $error("halt not entered"); // R2

    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == PD_HALT && wake) |=> (cause_q == PD_NONE)) else $error("halt not released"); // R3

    AST_HALT_IGNORES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == PD_HALT && !wake) |=> (cause_q == PD_HALT)) else $error("halt left without wake"); // R4

    AST_HOLD_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == PD_HOLD && hold_req) |=> (cause_q == PD_HOLD)) else $error("hold left under request"); // R8

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == PD_HOLD && !hold_req) |=> (cause_q == PD_NONE)) else $error("hold not released"); // R9
endmodule

// File: rtl/pd_ctrl.sv
// Top of the halt/hold power-down controller.
// Ties together the wake combiner, the bus-grant arbiter and the entry-cause tracker.
// Assumes: one clock domain, with all inputs synchronous to the rising edge.
module pd_ctrl
    import pd_pkg::*;
#(
    parameter int NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_stb,
    input  logic               hold_req,
    input  logic               xfer_done,
    input  logic [NUM_IRQ-1:0] irq_lines,
    output logic               hlda,
    output logic               bus_float,
    output logic               core_clk_en,
    output logic               pd_active
);
    logic      wake;
    logic      halted;
    pd_cause_t cause;

    pd_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_lines (irq_lines),
        .wake      (wake)
    );

    assign halted = (cause == PD_HALT);

    pd_hold_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .xfer_done (xfer_done),
        .halted    (halted),
        .hlda      (hlda),
        .bus_float (bus_float)
    );

    pd_cause_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_stb (halt_stb),
        .hold_req (hold_req),
        .hlda     (hlda),
        .wake     (wake),
        .cause    (cause)
    );

    assign pd_active   = (cause != PD_NONE);
    assign core_clk_en = ~pd_active;

    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_active && !halt_stb && hlda && hold_req) |=> pd_active) else $error("hold entry missed"); // R7

    AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> !core_clk_en) else $error("clock runs in power-down"); // R11
endmodule

// File: tb/tb_pd_ctrl.sv
module tb_pd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            halt_stb;
    logic            hold_req;
    logic            xfer_done;
    logic [NIRQ-1:0] irq_lines;
    logic            hlda;
    logic            bus_float;
    logic            core_clk_en;
    logic            pd_active;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_ctrl #(.NUM_IRQ(NIRQ)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_stb    (halt_stb),
        .hold_req    (hold_req),
        .xfer_done   (xfer_done),
        .irq_lines   (irq_lines),
        .hlda        (hlda),
        .bus_float   (bus_float),
        .core_clk_en (core_clk_en),
        .pd_active   (pd_active)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // advance to 2 time units after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0; halt_stb = 1'b0; hold_req = 1'b0; xfer_done = 1'b0; irq_lines = '0;
        step(); step(); step();
        // R1: state while in reset
        chk("R1 hlda", hlda, 1'b0);
        chk("R1 bus_float", bus_float, 1'b0);
        chk("R1 pd_active", pd_active, 1'b0);
        chk("R1 core_clk_en", core_clk_en, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R1 pd_active after release", pd_active, 1'b0);

        // R2/R3: halt entry, then every interrupt vector
        for (int v = 0; v < 32; v++) begin
            halt_stb = 1'b1;
            step();
            halt_stb = 1'b0;
            chk("R2 halt entry", pd_active, 1'b1);
            chk("R11 clk_en gated", core_clk_en, 1'b0);
            irq_lines = v[NIRQ-1:0];
            step();
            chk("R3 halt wake by vector", pd_active, (v == 0) ? 1'b1 : 1'b0);
            chk("R11 clk_en", core_clk_en, (v == 0) ? 1'b0 : 1'b1);
            if (v == 0) begin
                irq_lines = 5'b00001;
                step();
                chk("R3 halt wake lowest line", pd_active, 1'b0);
            end
            irq_lines = '0;
        end

        // R4: hold pulse during halt does not release it
        halt_stb = 1'b1;
        step();
        halt_stb = 1'b0;
        hold_req = 1'b1;
        xfer_done = 1'b0;
        step();
        chk("R5 grant while halted", hlda, 1'b1);
        chk("R4 still down", pd_active, 1'b1);
        step();
        chk("R6 float under halt grant", bus_float, 1'b1);
        hold_req = 1'b0;
        step();
        chk("R4 hlda drops", hlda, 1'b0);
        chk("R4 halt kept after hold removal", pd_active, 1'b1);
        step();
        chk("R4 halt kept later", pd_active, 1'b1);
        irq_lines = 5'b10000;
        step();
        chk("R3 wake by top line", pd_active, 1'b0);
        irq_lines = '0;

        // R5: grant waits for the transfer to end
        hold_req = 1'b1;
        xfer_done = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R5 no grant mid-transfer", hlda, 1'b0);
            chk("R7 no power-down before grant", pd_active, 1'b0);
        end
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        chk("R5 grant at transfer end", hlda, 1'b1);
        chk("R6 float not yet", bus_float, 1'b0);
        chk("R7 not yet down", pd_active, 1'b0);
        step();
        chk("R6 float one clock later", bus_float, 1'b1);
        chk("R7 hold entry", pd_active, 1'b1);
        chk("R11 clk_en gated in hold", core_clk_en, 1'b0);

        // R8: interrupts ignored during hold power-down
        for (int v = 1; v < 32; v++) begin
            irq_lines = v[NIRQ-1:0];
            step();
            chk("R8 irq ignored in hold", pd_active, 1'b1);
            chk("R5 grant held", hlda, 1'b1);
        end
        irq_lines = '0;

        // R9: release by removing the request, with a half-clock re-take
        hold_req = 1'b0;
        step();
        chk("R9 hlda falls", hlda, 1'b0);
        chk("R9 hold released", pd_active, 1'b0);
        chk("R9 float still on before falling edge", bus_float, 1'b1);
        #(CLK_PERIOD/2);
        chk("R9 float off after falling edge", bus_float, 1'b0);

        // R10: reset during a halt
        halt_stb = 1'b1;
        step();
        halt_stb = 1'b0;
        chk("R2 halt entry before reset", pd_active, 1'b1);
        do_reset();
        chk("R10 reset ends halt", pd_active, 1'b0);

        // R10: reset during a hold
        hold_req = 1'b1;
        xfer_done = 1'b1;
        step();
        step();
        xfer_done = 1'b0;
        chk("R7 hold entry before reset", pd_active, 1'b1);
        rst_n = 1'b0;
        hold_req = 1'b0;
        step();
        chk("R10 reset ends hold", pd_active, 1'b0);
        chk("R10 reset clears hlda", hlda, 1'b0);
        #(CLK_PERIOD/2);
        chk("R10 float off in reset", bus_float, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 clk_en after reset", core_clk_en, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule